// File: doc/BRIEF.md
# Double-Banked 64-Point Digit-Swap Reorder Buffer

This block sits between the stages of a 64-point FFT that is built from two 8-point passes. Such a pipeline hands its results over with the index digits exchanged: the sequence runs 0, 8, 16, ... 56, then 1, 9, 17, and so on. The buffer accepts one complex sample per clock, one frame of 64 samples at a time, and plays each completed frame back in the other digit order. A frame written in 8-inverse order therefore comes out in natural order, and a natural-order frame comes out in 8-inverse order.

Storage is split into two banks of 64 complex entries. The upstream stage fills one bank while the previous frame streams out of the other. When the 64th sample of a frame is stored, the banks change roles, a one-cycle frame-complete pulse is raised, and playback of that frame starts. A build parameter selects whether the index shuffle is placed on the write address or on the read address. Both placements produce the same output stream, so one design serves either position in the pipeline.

Top module: `fr_reorder_pp`

## Requirements
- R1: While reset is held and in the first cycle after it, `rd_valid` and `frame_done` are low.
- R2: `rd_valid` stays low until a first frame of 64 accepted samples has been written after reset. A partial frame produces no output.
- R3: `frame_done` is high for exactly one cycle. That cycle is the one right after the clock edge at which the 64th sample of a frame is accepted.
- R4: Playback starts in the same cycle as `frame_done` and lasts exactly 64 consecutive cycles. `rd_valid` then drops unless another frame has completed at that same edge.
- R5: The i-th output sample of a frame (i = 0..63, counted from the `frame_done` cycle) equals the input sample of that frame with index 8*(i mod 8) + i/8.
- R6: A frame written in 8-inverse order (input position k holds natural index 8*(k mod 8) + k/8) is played back in natural order 0..63.
- R7: Clock cycles with `wr_en` low store nothing and do not advance the frame position. Gaps in the input stream do not change which samples form a frame.
- R8: Back-to-back frames at one sample per clock are written while the previous frame plays back, with no lost or corrupted samples and no idle output cycle between frames.
- R9: The two settings of the shuffle-placement parameter produce identical `rd_valid`, `frame_done` and data streams for the same input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Input sample strobe |
| wr_re | input | DW | Input sample, real part |
| wr_im | input | DW | Input sample, imaginary part |
| rd_valid | output | 1 | Output sample is valid |
| rd_re | output | DW | Output sample, real part |
| rd_im | output | DW | Output sample, imaginary part |
| frame_done | output | 1 | Pulse marking a bank swap and the first sample of playback |

## Verification
The assertions assume that the upstream stage delivers at most one sample per clock. Under that assumption a frame can never complete before the previous frame has finished playing. The bench keeps to this: `wr_en` is driven once per clock and only from the negative edge. Its stimulus covers a partial frame, a frame with pseudo-random gaps, an 8-inverse frame and a run of back-to-back frames. Both parameter settings are instantiated on the same inputs, and every cycle is compared against a behavioural model of the two banks.

// File: rtl/fr_reorder_pkg.sv
// Package: shared settings for the reorder buffer.
// Assumes: nothing beyond standard SystemVerilog.
package fr_reorder_pkg;

    // Where the digit swap of the index is applied.
    typedef enum logic {
        SHUFFLE_ON_READ  = 1'b0,
        SHUFFLE_ON_WRITE = 1'b1
    } shuffle_side_e;

    localparam int DEF_DIGIT_BITS = 3;   // radix-8 digits
    localparam int DEF_SAMPLE_W   = 16;  // width of each component

endpackage

// File: rtl/fr_wr_ctrl.sv
// Module: write-side control. Counts accepted samples within a frame and
// owns the bank that is currently being filled. It raises swap in the
// cycle that accepts the last sample of a frame.
// Assumes: at most one sample per clock, wr_en is a clean strobe.
module fr_wr_ctrl #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    output logic [AW-1:0] wr_pos,
    output logic          wr_bank,
    output logic          swap
);
    localparam logic [AW-1:0] LAST_POS = {AW{1'b1}};

    // Frame end is reached when the last position is accepted.
    always_comb swap = wr_en && (wr_pos == LAST_POS);

    // Advance the position on each accepted sample, toggle bank on swap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_pos  <= '0;
            wr_bank <= 1'b0;
        end else if (wr_en) begin
            wr_pos <= wr_pos + 1'b1;
            if (swap) wr_bank <= ~wr_bank;
        end
    end

    assert_swap_flips_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
        swap |=> (wr_bank != $past(wr_bank)));

    assert_idle_holds_pos_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (wr_pos == $past(wr_pos)) && (wr_bank == $past(wr_bank)));

endmodule

// File: rtl/fr_rd_ctrl.sv
// Module: read-side control. Starts a 64-step playback on every swap,
// producing the playback position, valid and a frame-complete pulse.
// Assumes: swaps come no closer together than one full frame.
module fr_rd_ctrl #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          swap,
    output logic [AW-1:0] rd_pos,
    output logic          rd_valid,
    output logic          frame_done
);
    localparam logic [AW-1:0] LAST_POS = {AW{1'b1}};

    // Restart playback on swap, otherwise step through until the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pos     <= '0;
            rd_valid   <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= swap;
            if (swap) begin
                rd_pos   <= '0;
                rd_valid <= 1'b1;
            end else if (rd_valid) begin
                rd_pos <= rd_pos + 1'b1;
                if (rd_pos == LAST_POS) rd_valid <= 1'b0;
            end
        end
    end

    assert_valid_starts_with_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> frame_done);

    assert_done_after_swap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        swap |=> frame_done && rd_valid && (rd_pos == '0));

    assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    assert_playback_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && (rd_pos == LAST_POS) && !swap) |=> !rd_valid);

    assert_playback_steps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && (rd_pos != LAST_POS) && !swap) |=> rd_valid && (rd_pos == $past(rd_pos) + 1'b1));

endmodule

// File: rtl/fr_bank_mem.sv
// Module: two banks of complex samples. Synchronous write into the
// selected bank, asynchronous read from the other selected bank.
// Assumes: the caller never reads and writes the same bank at once.
module fr_bank_mem #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic          wbank,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata_re,
    input  logic [DW-1:0] wdata_im,
    input  logic          rbank,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata_re,
    output logic [DW-1:0] rdata_im
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_re [2][DEPTH];
    logic [DW-1:0] mem_im [2][DEPTH];

    // Store one sample into the fill bank.
    always_ff @(posedge clk) begin
        if (we) begin
            mem_re[wbank][waddr] <= wdata_re;
            mem_im[wbank][waddr] <= wdata_im;
        end
    end

    // Present the addressed sample of the playback bank.
    always_comb begin
        rdata_re = mem_re[rbank][raddr];
        rdata_im = mem_im[rbank][raddr];
    end

endmodule

// File: rtl/fr_reorder_pp.sv
// Module: top of the double-banked digit-swap reorder buffer. One bank
// fills while the other plays back; the two base-2^DIGIT_BITS digits of
// the index are exchanged on the side chosen by SHUFFLE_SIDE.
// Assumes: at most one input sample per clock, no backpressure.
module fr_reorder_pp
    import fr_reorder_pkg::*;
#(
    parameter int            DIGIT_BITS   = DEF_DIGIT_BITS,
    parameter int            DW           = DEF_SAMPLE_W,
    parameter shuffle_side_e SHUFFLE_SIDE = SHUFFLE_ON_READ
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_re,
    input  logic [DW-1:0] wr_im,
    output logic          rd_valid,
    output logic [DW-1:0] rd_re,
    output logic [DW-1:0] rd_im,
    output logic          frame_done
);
    localparam int AW = 2 * DIGIT_BITS;

    logic [AW-1:0] wr_pos, rd_pos, wr_addr, rd_addr, wr_swapd, rd_swapd;
    logic          wr_bank, swap;

    // Exchange the high and low digits of both positions.
    always_comb begin
        wr_swapd = {wr_pos[DIGIT_BITS-1:0], wr_pos[AW-1:DIGIT_BITS]};
        rd_swapd = {rd_pos[DIGIT_BITS-1:0], rd_pos[AW-1:DIGIT_BITS]};
    end

    generate
        if (SHUFFLE_SIDE == SHUFFLE_ON_WRITE) begin : g_shuffle_wr
            assign wr_addr = wr_swapd;
            assign rd_addr = rd_pos;
        end else begin : g_shuffle_rd
            assign wr_addr = wr_pos;
            assign rd_addr = rd_swapd;
        end
    endgenerate

    fr_wr_ctrl #(.AW(AW)) u_wr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_pos  (wr_pos),
        .wr_bank (wr_bank),
        .swap    (swap)
    );

    fr_rd_ctrl #(.AW(AW)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .swap       (swap),
        .rd_pos     (rd_pos),
        .rd_valid   (rd_valid),
        .frame_done (frame_done)
    );

    fr_bank_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk      (clk),
        .we       (wr_en),
        .wbank    (wr_bank),
        .waddr    (wr_addr),
        .wdata_re (wr_re),
        .wdata_im (wr_im),
        .rbank    (~wr_bank),
        .raddr    (rd_addr),
        .rdata_re (rd_re),
        .rdata_im (rd_im)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !rd_valid && !frame_done);

    assert_done_implies_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> rd_valid);

endmodule

// File: tb/sim_fr_reorder_pp.sv
module sim_fr_reorder_pp;
    import fr_reorder_pkg::*;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_re = '0;
    logic [DW-1:0] wr_im = '0;
    logic          v0, v1, d0, d1;
    logic [DW-1:0] re0, im0, re1, im1;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string tag = "R1";

    always #4 clk = ~clk;  // 125 MHz

    fr_reorder_pp #(.DW(DW), .SHUFFLE_SIDE(SHUFFLE_ON_READ)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_re(wr_re), .wr_im(wr_im),
        .rd_valid(v0), .rd_re(re0), .rd_im(im0), .frame_done(d0));

    fr_reorder_pp #(.DW(DW), .SHUFFLE_SIDE(SHUFFLE_ON_WRITE)) u1 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_re(wr_re), .wr_im(wr_im),
        .rd_valid(v1), .rd_re(re1), .rd_im(im1), .frame_done(d1));

    function automatic int digit_swap(int k);
        return 8 * (k % 8) + k / 8;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural model: a fill frame, a playback frame and a position.
    int fill_re[64], fill_im[64], play_re[64], play_im[64];
    int m_wpos = 0, m_rpos = 0;
    bit m_active = 0, m_done = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_wpos = 0; m_rpos = 0; m_active = 0; m_done = 0;
        end else begin
            m_done = 0;
            if (m_active) begin
                if (m_rpos == 63) m_active = 0;
                else m_rpos++;
            end
            if (wr_en) begin
                fill_re[m_wpos] = int'(wr_re);
                fill_im[m_wpos] = int'(wr_im);
                if (m_wpos == 63) begin
                    play_re = fill_re;
                    play_im = fill_im;
                    m_active = 1; m_rpos = 0; m_done = 1; m_wpos = 0;
                end else m_wpos++;
            end
        end
    end

    // Every-cycle comparison against the model and between both variants.
    always @(negedge clk) begin
        if (rst_n) begin
            check({tag, " R4 valid"}, 32'(v0), 32'(m_active));
            check({tag, " R3 done"}, 32'(d0), 32'(m_done));
            check({tag, " R9 valid"}, 32'(v1), 32'(v0));
            check({tag, " R9 done"}, 32'(d1), 32'(d0));
            if (m_active) begin
                check({tag, " R5 re"}, 32'(re0), 32'(play_re[digit_swap(m_rpos)]));
                check({tag, " R5 im"}, 32'(im0), 32'(play_im[digit_swap(m_rpos)]));
                check({tag, " R9 re"}, 32'(re1), 32'(re0));
                check({tag, " R9 im"}, 32'(im1), 32'(im0));
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL R4 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic put(int re, int im);
        @(negedge clk);
        wr_en = 1'b1;
        wr_re = DW'(re);
        wr_im = DW'(im);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en = 1'b0;
        end
    endtask

    initial begin
        int lfsr = 32'h1ace;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", 32'(v0), 32'd0);
        check("R1 done in reset", 32'(d0), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", 32'(v0), 32'd0);

        // Partial frame: 63 samples, then a pause.
        tag = "R2";
        for (int k = 0; k < 63; k++) put(k, 1000 + k);
        idle(6);
        check("R2 no output on partial frame", 32'(v0), 32'd0);
        put(63, 1063);
        idle(1);
        check("R3 pulse after last sample", 32'(d0), 32'd1);
        idle(70);
        check("R4 playback over", 32'(v0), 32'd0);

        // Frame with gaps.
        tag = "R7";
        for (int k = 0; k < 64; k++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hb400 : 0);
            if ((lfsr & 3) == 0) idle(1 + (lfsr >> 4) % 3);
            put(200 + k, 300 - k);
        end
        idle(70);

        // 8-inverse order frame must play back as 0..63.
        tag = "R6";
        for (int k = 0; k < 64; k++) put(digit_swap(k), 2 * digit_swap(k));
        @(negedge clk);
        wr_en = 1'b0;
        for (int i = 0; i < 64; i++) begin
            check("R6 natural order", 32'(re0), 32'(i));
            @(negedge clk);
        end
        idle(4);

        // Back-to-back frames.
        tag = "R8";
        for (int f = 0; f < 4; f++)
            for (int k = 0; k < 64; k++) put(4096 * (f + 1) + k, 7 * k + f);
        idle(1);
        for (int i = 0; i < 63; i++) begin
            check("R8 continuous output", 32'(v0), 32'd1);
            @(negedge clk);
        end
        idle(10);
        check("R4 idle after last frame", 32'(v0), 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule